// File: doc/BRIEF.md
# Outbound Request Timeout Tracker

This block watches a small, fixed set of outstanding outbound transactions on a packet link. Each transaction slot has three independent timers. The link-acknowledge timer runs from transmission until the partner accepts the packet. The response timer runs from transmission until the matching response arrives. The lifetime timer runs from the moment the logical layer takes the request until the packet is accepted on the link. Event pulses carry a slot index. All timers advance only on a shared prescaled tick.

An expiry is queued on one report stream per timer type. Each stream uses valid/ready handshaking. A link-acknowledge expiry latches a sticky output-stopped flag. A lifetime expiry latches a sticky drain flag, and while that flag is set, transmit events are discarded. Each sticky flag stays set until its own software clear input is pulsed. The three timeout limits are writable only while nothing is outstanding. A limit set in which the lifetime limit does not exceed the link limit is flagged.

Back-pressure on the report streams works as follows. Once a stream raises valid, valid and the reported index stay unchanged until ready is seen high at a clock edge. Further expiries wait in a per-slot pending set meanwhile, and no expiry is lost. Expiries of the same type that occur together are delivered in ascending slot order.

Top module: `req_timeout_tracker`

## Requirements
- R1: The link timer of slot i starts (count cleared) on a transmit event for i and stops on an accept event for i. After the limit's worth of ticks it expires, and the index is reported on stream 0 (`err_valid[0]`, `err_idx[IDX_W-1:0]`).
- R2: The response timer of slot i starts on a transmit event for i and stops on a response event for i. Its expiry is reported on stream 1 (`err_idx[2*IDX_W-1:IDX_W]`).
- R3: The lifetime timer of slot i starts on a request event for i and stops on an accept event for i. Its expiry is reported on stream 2 (`err_idx[3*IDX_W-1:2*IDX_W]`).
- R4: Any link timer expiry sets `out_stopped` in the next cycle. The flag stays set until `stop_clr` is pulsed. A new expiry in the same cycle as the clear wins.
- R5: Any lifetime expiry sets `drain` in the next cycle. The flag stays set until `drain_clr` is pulsed, with set winning over clear. While `drain` is high, transmit events are ignored and start no timer.
- R6: A configuration write (`cfg_we`) is ignored while `outstanding` is non-zero.
- R7: `cfg_bad` is high whenever the active lifetime limit is less than or equal to the active link limit.
- R8: An accept event for a slot whose link timer is idle, or a response event for a slot whose response timer is idle, has no effect.
- R9: An expiry on tick cycle T is presented on its stream from cycle T+2, provided the stream is free. Expiries of one type that occur together are presented lowest index first.
- R10: While `err_valid[k]` is high and `err_ready[k]` is low, valid stays high and the reported index is unchanged.
- R11: `outstanding` equals the number of slots that have at least one active timer.
- R12: Timers advance only in cycles with `tick` high. A limit L expires on the L-th tick after the start, and a limit of 0 acts as 1. In a cycle with both a start and a stop, the start wins over the stop and over expiry.
- R13: After reset, no stream is valid, `drain`, `out_stopped` and `cfg_bad` are low, `outstanding` is 0, and the limits are link 8, response 12 and lifetime 16 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled timer advance strobe |
| req_valid | input | 1 | Logical layer took a request |
| req_idx | input | IDX_W | Slot of the request |
| tx_valid | input | 1 | Request packet transmitted |
| tx_idx | input | IDX_W | Slot transmitted |
| acc_valid | input | 1 | Partner accepted the packet |
| acc_idx | input | IDX_W | Slot accepted |
| rsp_valid | input | 1 | Response packet received |
| rsp_idx | input | IDX_W | Slot of the response |
| cfg_we | input | 1 | Write the three limits |
| cfg_link_lim | input | CNT_W | New link limit in ticks |
| cfg_rsp_lim | input | CNT_W | New response limit in ticks |
| cfg_ttl_lim | input | CNT_W | New lifetime limit in ticks |
| drain_clr | input | 1 | Software clear of the drain flag |
| stop_clr | input | 1 | Software clear of the output-stopped flag |
| err_ready | input | 3 | Ready per report stream (0 link, 1 response, 2 lifetime) |
| err_valid | output | 3 | Valid per report stream |
| err_idx | output | 3*IDX_W | Failing slot per stream, stream k at bits k*IDX_W |
| drain | output | 1 | Outbound drain state |
| out_stopped | output | 1 | Output error-stopped state |
| outstanding | output | OC_W | Number of busy slots |
| cfg_bad | output | 1 | Lifetime limit not above link limit |

## Verification
If a slot's counter or active bit is corrupted, a report appears too early, too late or never. The stream compare catches this within two cycles of the tick on which the reference expires. `outstanding` also exposes a stuck or lost active bit in the cycle after the faulty event. A broken pending set or selection shows up on the next handshake as an index out of order, a repeated index or a missing index. Errors in the sticky flags or the configuration lock appear one cycle later on `drain`, `out_stopped` or `cfg_bad`, and in the timing of later expiries.

// File: rtl/rtt_pkg.sv
package rtt_pkg;
  typedef enum logic [1:0] {
    TMR_LINK = 2'd0,
    TMR_RSP  = 2'd1,
    TMR_TTL  = 2'd2
  } tmr_e;

  localparam int unsigned NUM_TMR = 3;
endpackage

// File: rtl/rtt_timer.sv
module rtt_timer #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic             stop,
  input  logic [CNT_W-1:0] limit,
  output logic             active,
  output logic             expire
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   cnt_inc;

  assign cnt_inc = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    expire = tick && active && !start && !stop && (cnt_inc >= {1'b0, limit});
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (start) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (stop || expire) begin
      active <= 1'b0;
    end else if (tick && active) begin
      cnt <= cnt_inc[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/rtt_report.sv
module rtt_report #(
  parameter int unsigned N     = 4,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     set,
  input  logic             ready,
  output logic             valid,
  output logic [IDX_W-1:0] idx
);
  logic [N-1:0]     pend;
  logic             any;
  logic [IDX_W-1:0] low;
  logic [N-1:0]     low_oh;
  logic             load;

  always_comb begin
    any    = 1'b0;
    low    = '0;
    low_oh = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        any    = 1'b1;
        low    = IDX_W'(i);
        low_oh = N'(1) << i;
      end
    end
  end

  assign load = !valid || ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend  <= '0;
      valid <= 1'b0;
      idx   <= '0;
    end else if (load && any) begin
      valid <= 1'b1;
      idx   <= low;
      pend  <= (pend & ~low_oh) | set;
    end else begin
      if (load) valid <= 1'b0;
      pend <= pend | set;
    end
  end
endmodule

// File: rtl/rtt_cfg.sv
module rtt_cfg #(
  parameter int unsigned CNT_W    = 10,
  parameter int unsigned DEF_LINK = 8,
  parameter int unsigned DEF_RSP  = 12,
  parameter int unsigned DEF_TTL  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic             busy,
  input  logic [CNT_W-1:0] in_link,
  input  logic [CNT_W-1:0] in_rsp,
  input  logic [CNT_W-1:0] in_ttl,
  output logic [CNT_W-1:0] link_lim,
  output logic [CNT_W-1:0] rsp_lim,
  output logic [CNT_W-1:0] ttl_lim,
  output logic             bad
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_lim <= CNT_W'(DEF_LINK);
      rsp_lim  <= CNT_W'(DEF_RSP);
      ttl_lim  <= CNT_W'(DEF_TTL);
    end else if (we && !busy) begin
      link_lim <= in_link;
      rsp_lim  <= in_rsp;
      ttl_lim  <= in_ttl;
    end
  end

  assign bad = (ttl_lim <= link_lim);
endmodule

// File: rtl/req_timeout_tracker.sv
module req_timeout_tracker #(
  parameter int unsigned N     = 4,
  parameter int unsigned CNT_W = 10,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1,
  parameter int unsigned OC_W  = $clog2(N + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick,
  input  logic                  req_valid,
  input  logic [IDX_W-1:0]      req_idx,
  input  logic                  tx_valid,
  input  logic [IDX_W-1:0]      tx_idx,
  input  logic                  acc_valid,
  input  logic [IDX_W-1:0]      acc_idx,
  input  logic                  rsp_valid,
  input  logic [IDX_W-1:0]      rsp_idx,
  input  logic                  cfg_we,
  input  logic [CNT_W-1:0]      cfg_link_lim,
  input  logic [CNT_W-1:0]      cfg_rsp_lim,
  input  logic [CNT_W-1:0]      cfg_ttl_lim,
  input  logic                  drain_clr,
  input  logic                  stop_clr,
  input  logic [2:0]            err_ready,
  output logic [2:0]            err_valid,
  output logic [3*IDX_W-1:0]    err_idx,
  output logic                  drain,
  output logic                  out_stopped,
  output logic [OC_W-1:0]       outstanding,
  output logic                  cfg_bad
);
  import rtt_pkg::*;

  logic [NUM_TMR-1:0][N-1:0]     act;
  logic [NUM_TMR-1:0][N-1:0]     expv;
  logic [NUM_TMR-1:0][N-1:0]     start_v;
  logic [NUM_TMR-1:0][N-1:0]     stop_v;
  logic [NUM_TMR-1:0][CNT_W-1:0] lim;
  logic [CNT_W-1:0]              link_lim, rsp_lim, ttl_lim;
  logic [N-1:0]                  busy_v;
  logic                          busy;

  rtt_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (cfg_we),
    .busy    (busy),
    .in_link (cfg_link_lim),
    .in_rsp  (cfg_rsp_lim),
    .in_ttl  (cfg_ttl_lim),
    .link_lim(link_lim),
    .rsp_lim (rsp_lim),
    .ttl_lim (ttl_lim),
    .bad     (cfg_bad)
  );

  assign lim[TMR_LINK] = link_lim;
  assign lim[TMR_RSP]  = rsp_lim;
  assign lim[TMR_TTL]  = ttl_lim;

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic req_hit, tx_hit, acc_hit, rsp_hit;

    assign req_hit = req_valid && (req_idx == IDX_W'(i));
    assign tx_hit  = tx_valid && !drain && (tx_idx == IDX_W'(i));
    assign acc_hit = acc_valid && (acc_idx == IDX_W'(i)) && act[TMR_LINK][i];
    assign rsp_hit = rsp_valid && (rsp_idx == IDX_W'(i)) && act[TMR_RSP][i];

    assign start_v[TMR_LINK][i] = tx_hit;
    assign stop_v[TMR_LINK][i]  = acc_hit;
    assign start_v[TMR_RSP][i]  = tx_hit;
    assign stop_v[TMR_RSP][i]   = rsp_hit;
    assign start_v[TMR_TTL][i]  = req_hit;
    assign stop_v[TMR_TTL][i]   = acc_hit;

    for (genvar k = 0; k < NUM_TMR; k++) begin : g_tmr
      rtt_timer #(.CNT_W(CNT_W)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .start (start_v[k][i]),
        .stop  (stop_v[k][i]),
        .limit (lim[k]),
        .active(act[k][i]),
        .expire(expv[k][i])
      );
    end

    assign busy_v[i] = act[TMR_LINK][i] || act[TMR_RSP][i] || act[TMR_TTL][i];
  end

  for (genvar k = 0; k < NUM_TMR; k++) begin : g_rep
    rtt_report #(.N(N), .IDX_W(IDX_W)) u_rep (
      .clk  (clk),
      .rst_n(rst_n),
      .set  (expv[k]),
      .ready(err_ready[k]),
      .valid(err_valid[k]),
      .idx  (err_idx[k*IDX_W +: IDX_W])
    );
  end

  always_comb begin
    outstanding = '0;
    for (int i = 0; i < N; i++) begin
      outstanding = outstanding + OC_W'(busy_v[i]);
    end
  end

  assign busy = |busy_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      drain       <= 1'b0;
      out_stopped <= 1'b0;
    end else begin
      drain       <= (|expv[TMR_TTL])  || (drain && !drain_clr);
      out_stopped <= (|expv[TMR_LINK]) || (out_stopped && !stop_clr);
    end
  end
endmodule

// File: rtl/rtt_checker.sv
module rtt_checker #(
  parameter int unsigned N     = 4,
  parameter int unsigned CNT_W = 10,
  parameter int unsigned IDX_W = 2,
  parameter int unsigned OC_W  = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               drain,
  input logic               drain_clr,
  input logic               out_stopped,
  input logic               stop_clr,
  input logic [2:0]         err_valid,
  input logic [2:0]         err_ready,
  input logic [3*IDX_W-1:0] err_idx,
  input logic [OC_W-1:0]    outstanding,
  input logic [CNT_W-1:0]   link_lim,
  input logic [CNT_W-1:0]   rsp_lim,
  input logic [CNT_W-1:0]   ttl_lim
);
  p_drain_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drain && !drain_clr |=> drain);

  p_stop_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_stopped && !stop_clr |=> out_stopped);

  p_cfg_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding != '0 |=> $stable(link_lim) && $stable(rsp_lim) && $stable(ttl_lim));

  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= OC_W'(N));

  for (genvar k = 0; k < 3; k++) begin : g_hold
    p_valid_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid[k] && !err_ready[k] |=> err_valid[k] && $stable(err_idx[k*IDX_W +: IDX_W]));
  end
endmodule

bind req_timeout_tracker rtt_checker #(
  .N(N), .CNT_W(CNT_W), .IDX_W(IDX_W), .OC_W(OC_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .drain      (drain),
  .drain_clr  (drain_clr),
  .out_stopped(out_stopped),
  .stop_clr   (stop_clr),
  .err_valid  (err_valid),
  .err_ready  (err_ready),
  .err_idx    (err_idx),
  .outstanding(outstanding),
  .link_lim   (link_lim),
  .rsp_lim    (rsp_lim),
  .ttl_lim    (ttl_lim)
);

// File: tb/req_timeout_tracker_bench.sv
module req_timeout_tracker_bench;
  localparam int N     = 4;
  localparam int CNT_W = 10;
  localparam int IDX_W = 2;
  localparam int OC_W  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic req_valid = 1'b0, tx_valid = 1'b0, acc_valid = 1'b0, rsp_valid = 1'b0;
  logic [IDX_W-1:0] req_idx = '0, tx_idx = '0, acc_idx = '0, rsp_idx = '0;
  logic cfg_we = 1'b0;
  logic [CNT_W-1:0] cfg_link_lim = '0, cfg_rsp_lim = '0, cfg_ttl_lim = '0;
  logic drain_clr = 1'b0, stop_clr = 1'b0;
  logic [2:0] err_ready = 3'b111;
  logic [2:0] err_valid;
  logic [3*IDX_W-1:0] err_idx;
  logic drain, out_stopped, cfg_bad;
  logic [OC_W-1:0] outstanding;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  req_timeout_tracker #(.N(N), .CNT_W(CNT_W)) u_req_timeout_tracker (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .req_valid(req_valid), .req_idx(req_idx),
    .tx_valid(tx_valid), .tx_idx(tx_idx),
    .acc_valid(acc_valid), .acc_idx(acc_idx),
    .rsp_valid(rsp_valid), .rsp_idx(rsp_idx),
    .cfg_we(cfg_we), .cfg_link_lim(cfg_link_lim), .cfg_rsp_lim(cfg_rsp_lim),
    .cfg_ttl_lim(cfg_ttl_lim), .drain_clr(drain_clr), .stop_clr(stop_clr),
    .err_ready(err_ready), .err_valid(err_valid), .err_idx(err_idx),
    .drain(drain), .out_stopped(out_stopped), .outstanding(outstanding),
    .cfg_bad(cfg_bad)
  );

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  function automatic int idx_of(int k);
    return int'(err_idx[k*IDX_W +: IDX_W]);
  endfunction

  // Reference model of the requirements
  int m_cnt[3][N];
  bit m_act[3][N];
  bit m_pend[3][N];
  bit m_ov[3];
  int m_oi[3];
  bit m_drain, m_stop;
  int m_lim[3];

  function automatic int m_count();
    int c = 0;
    for (int i = 0; i < N; i++) if (m_act[0][i] || m_act[1][i] || m_act[2][i]) c++;
    return c;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin
        for (int i = 0; i < N; i++) begin
          m_cnt[k][i] = 0; m_act[k][i] = 0; m_pend[k][i] = 0;
        end
        m_ov[k] = 0; m_oi[k] = 0;
      end
      m_drain = 0; m_stop = 0;
      m_lim[0] = 8; m_lim[1] = 12; m_lim[2] = 16;
    end else begin
      bit ex[3][N];
      bit st, sp, ackh, any_link, any_ttl, busy;
      busy = (m_count() != 0);
      any_link = 0; any_ttl = 0;
      for (int i = 0; i < N; i++) begin
        ackh = acc_valid && (int'(acc_idx) == i) && m_act[0][i];
        for (int k = 0; k < 3; k++) begin
          if (k == 2) st = req_valid && (int'(req_idx) == i);
          else        st = tx_valid && !m_drain && (int'(tx_idx) == i);
          if (k == 1) sp = rsp_valid && (int'(rsp_idx) == i) && m_act[1][i];
          else        sp = ackh;
          ex[k][i] = tick && m_act[k][i] && !st && !sp && (m_cnt[k][i] + 1 >= m_lim[k]);
          if (st) begin m_act[k][i] = 1; m_cnt[k][i] = 0; end
          else if (sp || ex[k][i]) m_act[k][i] = 0;
          else if (tick && m_act[k][i]) m_cnt[k][i]++;
        end
        any_link |= ex[0][i];
        any_ttl  |= ex[2][i];
      end
      for (int k = 0; k < 3; k++) begin
        int low;
        low = -1;
        for (int i = N - 1; i >= 0; i--) if (m_pend[k][i]) low = i;
        if ((!m_ov[k] || err_ready[k]) && low >= 0) begin
          m_ov[k] = 1; m_oi[k] = low; m_pend[k][low] = 0;
        end else if (!m_ov[k] || err_ready[k]) begin
          m_ov[k] = 0;
        end
        for (int i = 0; i < N; i++) m_pend[k][i] |= ex[k][i];
      end
      m_drain = any_ttl || (m_drain && !drain_clr);
      m_stop  = any_link || (m_stop && !stop_clr);
      if (cfg_we && !busy) begin
        m_lim[0] = int'(cfg_link_lim); m_lim[1] = int'(cfg_rsp_lim); m_lim[2] = int'(cfg_ttl_lim);
      end
    end
  end

  // Cycle-by-cycle comparison, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      cycles++;
      check("R11 outstanding", int'(outstanding), m_count());
      check("R5 drain", int'(drain), int'(m_drain));
      check("R4 out_stopped", int'(out_stopped), int'(m_stop));
      check("R7 cfg_bad", int'(cfg_bad), int'(m_lim[2] <= m_lim[0]));
      for (int k = 0; k < 3; k++) begin
        string tg;
        tg = (k == 0) ? "R1 link stream valid" : (k == 1) ? "R2 response stream valid" : "R3 lifetime stream valid";
        check(tg, int'(err_valid[k]), int'(m_ov[k]));
        if (err_valid[k] && m_ov[k]) check("R9 reported index", idx_of(k), m_oi[k]);
      end
      if (cycles > 100000) begin
        n_errors++;
        $display("FAIL watchdog: actual=%0d expected<=100000", cycles);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
      end
    end
  end

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_ev();
    req_valid = 0; tx_valid = 0; acc_valid = 0; rsp_valid = 0; tick = 0;
    cfg_we = 0; drain_clr = 0; stop_clr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tick = 1; step(); tick = 0;
    end
  endtask

  task automatic do_req(int i);  req_valid = 1; req_idx = IDX_W'(i); step(); clear_ev(); endtask
  task automatic do_tx(int i);   tx_valid = 1;  tx_idx = IDX_W'(i);  step(); clear_ev(); endtask
  task automatic do_acc(int i);  acc_valid = 1; acc_idx = IDX_W'(i); step(); clear_ev(); endtask
  task automatic do_rsp(int i);  rsp_valid = 1; rsp_idx = IDX_W'(i); step(); clear_ev(); endtask
  task automatic do_cfg(int l, int r, int t);
    cfg_we = 1; cfg_link_lim = CNT_W'(l); cfg_rsp_lim = CNT_W'(r); cfg_ttl_lim = CNT_W'(t);
    step(); clear_ev();
  endtask

  initial begin
    void'($urandom(32'd7341));
    step(2);
    rst_n = 1;
    step();
    // R13 reset state
    check("R13 valid after reset", int'(err_valid), 0);
    check("R13 outstanding after reset", int'(outstanding), 0);
    check("R13 drain/stopped after reset", int'(drain) + int'(out_stopped), 0);
    check("R13 cfg_bad after reset", int'(cfg_bad), 0);

    // R12: no ticks, no expiry
    do_req(0);
    step(40);
    check("R12 no advance without tick", int'(err_valid[2]), 0);
    check("R12 still outstanding", int'(outstanding), 1);

    // R8: accept with idle link timer, response with idle response timer
    do_acc(0);
    do_rsp(2);
    check("R8 stray stop ignored", int'(outstanding), 1);

    // Lifetime expiry after 16 ticks with the stream held (R10)
    err_ready = 3'b000;
    ticks(16);
    step();
    check("R8 lifetime still expired", int'(err_valid[2]), 1);
    for (int c = 0; c < 3; c++) begin
      check("R10 valid held", int'(err_valid[2]), 1);
      check("R10 index held", idx_of(2), 0);
      step();
    end
    err_ready = 3'b111;
    step();
    check("R10 released after ready", int'(err_valid[2]), 0);

    // R5: drain set, transmit ignored
    check("R5 drain set", int'(drain), 1);
    do_tx(1);
    check("R5 transmit dropped in drain", int'(outstanding), 0);
    drain_clr = 1; step(); clear_ev();
    check("R5 drain cleared", int'(drain), 0);

    // R6: write while busy ignored
    do_req(1);
    do_cfg(8, 12, 2);
    check("R6 write ignored while busy", int'(cfg_bad), 0);
    do_tx(1); do_acc(1); do_rsp(1);
    check("R1 accept stops link and lifetime", int'(outstanding), 0);

    // R7: bad limit set accepted when idle, flagged
    do_cfg(6, 5, 4);
    check("R7 bad limit flagged", int'(cfg_bad), 1);
    do_cfg(3, 5, 7);
    check("R7 good limit", int'(cfg_bad), 0);

    // R9: two link expiries on the same tick, ascending order
    do_tx(2); do_tx(1);
    ticks(3);
    step();
    check("R9 first index", idx_of(0), 1);
    check("R9 first valid", int'(err_valid[0]), 1);
    step();
    check("R9 second index", idx_of(0), 2);
    check("R4 stopped after link expiry", int'(out_stopped), 1);
    ticks(3);
    step(3);
    stop_clr = 1; step(); clear_ev();
    check("R4 stopped cleared", int'(out_stopped), 0);

    // Constrained random mix
    for (int c = 0; c < 4000; c++) begin
      tick      = ($urandom_range(0, 2) == 0);
      req_valid = ($urandom_range(0, 5) == 0); req_idx = IDX_W'($urandom_range(0, N - 1));
      tx_valid  = ($urandom_range(0, 5) == 0); tx_idx  = IDX_W'($urandom_range(0, N - 1));
      acc_valid = ($urandom_range(0, 6) == 0); acc_idx = IDX_W'($urandom_range(0, N - 1));
      rsp_valid = ($urandom_range(0, 6) == 0); rsp_idx = IDX_W'($urandom_range(0, N - 1));
      cfg_we    = ($urandom_range(0, 30) == 0);
      cfg_link_lim = CNT_W'($urandom_range(0, 12));
      cfg_rsp_lim  = CNT_W'($urandom_range(0, 15));
      cfg_ttl_lim  = CNT_W'($urandom_range(0, 20));
      drain_clr = ($urandom_range(0, 40) == 0);
      stop_clr  = ($urandom_range(0, 40) == 0);
      err_ready = 3'($urandom_range(0, 7));
      step();
    end
    clear_ev();
    err_ready = 3'b111;
    step(5);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule